// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio M and emits one single-cycle pulse per M input cycles toward a phase detector. A 16-bit ratio word holds two fields. The low field sets how many prescaler cycles divide by 33. The high field sets how many prescaler cycles make up one output period in total. A dual-modulus prescaler built as synchronous logic on the input clock divides by 33 while the swallow count is nonzero and by 32 after it reaches zero, until the main count runs out.

Both counters reload from the ratio input at the end of every output period, so a ratio change takes effect only at a period boundary. Taking the run control low puts the block in standby: both counters stop, the prescaler clears, and the counters stay loaded from the ratio input, so the first period after the run control returns is a full one. Ratios below 992 are flagged on an error output and still give a defined period.

Top module: `psd_divider`

## Requirements
- R1: The ratio word splits into a swallow count A = ratio_i[4:0] and a main count B = ratio_i[15:5].
- R2: With B ≥ A and B ≥ 1, running pulses come exactly 32·B + A input cycles apart. The first pulse after run_i rises comes 32·B + A cycles after the first clock edge that samples run_i high.
- R3: Each prescaler cycle lasts 33 input cycles while the swallow counter is nonzero and 32 cycles once it is zero.
- R4: div_o is high for exactly one input cycle per output period.
- R5: A ratio change made during a period does not alter that period. The ratio present at the closing edge of a period sets the length of the next one.
- R6: While run_i is low, div_o stays low and both counters are held loaded from ratio_i. After run_i returns high, the first pulse comes one full period later.
- R7: ratio_err_o goes high when the ratio loaded into the counters is below 992 and low otherwise. It changes only when the counters load.
- R8: For out-of-range ratios, B = 0 acts as B = 1 and A is clamped to B. The period is then 32·B' + A' (for example: ratio 0 gives 32, ratio 5 gives 33, ratio 991 gives 990).
- R9: After reset, div_o and ratio_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run control; low holds and reloads the counters |
| ratio_i | input | 16 | Division ratio word {B, A} from the ratio latch |
| div_o | output | 1 | Divided pulse, one cycle wide |
| ratio_err_o | output | 1 | Loaded ratio is below the continuous-counting minimum |

## Verification
On every cycle the assertions check these properties: the pulse is one cycle wide, no pulse appears in standby, each prescaler cycle has the length set by the swallow state, the main counter never holds zero while running, and the error flag holds steady between loads. The exact period for a given ratio, the clamping of bad ratios, and the moment a changed ratio takes effect appear only in the bench's measured pulse spacing. So do the full first period after standby and the error level for each ratio.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PSD_P_W   = 5;
  localparam int unsigned PSD_B_W   = 11;
  localparam int unsigned PSD_RATIO_W = PSD_P_W + PSD_B_W;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned P_W = psd_pkg::PSD_P_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic swallow_i,
  output logic tick_o
);
  localparam int unsigned CW = P_W + 1;
  localparam logic [CW-1:0] TERM_P  = CW'((1 << P_W) - 1);
  localparam logic [CW-1:0] TERM_P1 = CW'(1 << P_W);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  // swallow only changes on a tick, so the modulus is stable within a cycle
  assign term   = swallow_i ? TERM_P1 : TERM_P;
  assign tick_o = !clr_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl #(
  parameter int unsigned P_W = psd_pkg::PSD_P_W,
  parameter int unsigned B_W = psd_pkg::PSD_B_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [P_W+B_W-1:0] ratio_i,
  input  logic             pre_tick_i,
  output logic             swallow_o,
  output logic             div_o,
  output logic             err_o,
  output logic [B_W-1:0]   b_cnt_o
);
  localparam int unsigned RW = P_W + B_W;
  localparam int unsigned MIN_RATIO = (1 << P_W) * ((1 << P_W) - 1);

  logic [P_W-1:0] a_in, a_eff, a_q;
  logic [B_W-1:0] b_in, b_eff, b_q;
  logic           last, load, bad;

  assign a_in  = ratio_i[P_W-1:0];
  assign b_in  = ratio_i[RW-1:P_W];
  assign b_eff = (b_in == '0) ? B_W'(1) : b_in;
  // clamp swallow count to main count for B < A
  assign a_eff = (B_W'(a_in) > b_eff) ? b_eff[P_W-1:0] : a_in;
  assign bad   = (32'(ratio_i) < MIN_RATIO);

  assign last  = (b_q == B_W'(1));
  assign load  = !run_i || (pre_tick_i && last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= B_W'(1);
      err_o <= 1'b0;
      div_o <= 1'b0;
    end else begin
      div_o <= run_i && pre_tick_i && last;
      if (load) begin
        a_q   <= a_eff;
        b_q   <= b_eff;
        err_o <= bad;
      end else if (pre_tick_i) begin
        b_q <= b_q - 1'b1;
        if (a_q != '0) a_q <= a_q - 1'b1;
      end
    end
  end

  assign swallow_o = (a_q != '0);
  assign b_cnt_o   = b_q;
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
  parameter int unsigned P_W = psd_pkg::PSD_P_W,
  parameter int unsigned B_W = psd_pkg::PSD_B_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [P_W+B_W-1:0] ratio_i,
  output logic               div_o,
  output logic               ratio_err_o
);
  logic           pre_tick;
  logic           swallow;
  logic [B_W-1:0] b_cnt;

  psd_prescaler #(.P_W(P_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!run_i),
    .swallow_i (swallow),
    .tick_o    (pre_tick)
  );

  psd_ctrl #(.P_W(P_W), .B_W(B_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .ratio_i    (ratio_i),
    .pre_tick_i (pre_tick),
    .swallow_o  (swallow),
    .div_o      (div_o),
    .err_o      (ratio_err_o),
    .b_cnt_o    (b_cnt)
  );
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
  parameter int unsigned P_W = psd_pkg::PSD_P_W,
  parameter int unsigned B_W = psd_pkg::PSD_B_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic           div_o,
  input logic           ratio_err_o,
  input logic           pre_tick,
  input logic           swallow,
  input logic [B_W-1:0] b_cnt
);
  logic [P_W+1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= '0;
    else if (!run_i)   gap_q <= '0;
    else if (pre_tick) gap_q <= '0;
    else               gap_q <= gap_q + 1'b1;
  end

  a_r3_prescale_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pre_tick) |-> (32'(gap_q) + 1 == (swallow ? (1 << P_W) + 1 : (1 << P_W))));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !div_o);

  a_r8_main_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (b_cnt != '0));

  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !div_o) |-> $stable(ratio_err_o));
endmodule

bind psd_divider psd_divider_chk #(.P_W(P_W), .B_W(B_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .div_o       (div_o),
  .ratio_err_o (ratio_err_o),
  .pre_tick    (pre_tick),
  .swallow     (swallow),
  .b_cnt       (b_cnt)
);

// File: tb/tb_psd_divider.sv
module tb_psd_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 199000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] ratio_i = '0;
  logic        div_o, ratio_err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psd_divider dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .ratio_i(ratio_i), .div_o(div_o), .ratio_err_o(ratio_err_o)
  );

  function automatic int exp_period(input logic [15:0] r);
    int b, a;
    b = int'(r[15:5]);
    a = int'(r[4:0]);
    if (b == 0) b = 1;
    if (a > b) a = b;
    return 32 * b + a;
  endfunction

  function automatic bit exp_err(input logic [15:0] r);
    return int'(r) < 992;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until a pulse is seen; checks the pulse width (R4)
  task automatic wait_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk_i);
      cnt++;
    end while (!div_o);
    @(negedge clk_i);
    check(!div_o, "R4", int'(div_o), 0);
    cnt = cnt;
  endtask

  // interval measurement after a pulse: one cycle already spent in wait_pulse's width check
  task automatic next_interval(output int cnt);
    int c;
    wait_pulse(c);
    cnt = c + 1;
  endtask

  task automatic start(input logic [15:0] r);
    @(negedge clk_i);
    run_i = 1'b0;
    ratio_i = r;
    @(negedge clk_i);
    @(negedge clk_i);
    run_i = 1'b1;
  endtask

  task automatic run_ratio(input logic [15:0] r, input int n_int, input string req);
    int c;
    start(r);
    wait_pulse(c);
    check(c == exp_period(r), req, c, exp_period(r));
    check(ratio_err_o == exp_err(r), "R7", int'(ratio_err_o), int'(exp_err(r)));
    for (int i = 1; i < n_int; i++) begin
      next_interval(c);
      check(c == exp_period(r), req, c, exp_period(r));
    end
  endtask

  initial begin
    int c;
    logic [15:0] r1, r2;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check(div_o == 1'b0, "R9", int'(div_o), 0);
    check(ratio_err_o == 1'b0, "R9", int'(ratio_err_o), 0);
    rst_ni = 1'b1;

    // directed corners
    run_ratio(16'd992, 3, "R2");
    run_ratio({11'd40, 5'd7}, 2, "R1");          // 1287
    run_ratio(16'd991, 2, "R8");                 // clamp to 990
    run_ratio(16'd0, 3, "R8");                   // 32
    run_ratio(16'd5, 3, "R8");                   // 33
    run_ratio({11'd31, 5'd31}, 2, "R2");         // B == A, 1023

    // R5: change after a pulse; one more old period, then new
    r1 = 16'd1500; r2 = 16'd2100;
    start(r1);
    wait_pulse(c);
    ratio_i = r2;
    c = c; // current period already loaded with r1
    next_interval(c);
    check(c == exp_period(r1), "R5", c, exp_period(r1));
    next_interval(c);
    check(c == exp_period(r2), "R5", c, exp_period(r2));
    // change mid-period
    repeat (300) @(negedge clk_i);
    ratio_i = r1;
    begin
      int c2;
      wait_pulse(c2);
      check(c2 + 300 + 1 == exp_period(r2), "R5", c2 + 301, exp_period(r2));
    end
    next_interval(c);
    check(c == exp_period(r1), "R5", c, exp_period(r1));

    // R6: standby mid-period, no pulses, full period after resume
    begin
      int pulses;
      repeat (400) @(negedge clk_i);
      run_i = 1'b0;
      pulses = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk_i);
        if (div_o) pulses++;
      end
      check(pulses == 0, "R6", pulses, 0);
      run_i = 1'b1;
      wait_pulse(c);
      check(c == exp_period(r1), "R6", c, exp_period(r1));
    end

    // random ratios in range
    for (int k = 0; k < 12; k++) begin
      logic [15:0] r;
      r = 16'($urandom_range(3000, 992));
      run_ratio(r, 2, "R2");
    end

    // full-scale ratio, first period only
    run_ratio(16'hFFFF, 1, "R2");

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (WATCHDOG_CYC) @(posedge clk_i);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule